// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a bank of maskable peripheral interrupt lines and a small group of nonmaskable trap lines, and presents the CPU with one interrupt request. Along with that request it supplies the index of the winning source and the program-memory address of that source's vector entry. The CPU fetches the handler address from that entry.

Each maskable source has an enable bit and a 3-bit user priority. Arbitration works in two stages. Pending traps come first, and they cannot be masked. Next comes the highest user priority that is above the CPU's current priority. Ties within one level go to the lower vector index. A select input redirects every lookup from the primary table to an alternate table of the same layout that sits right after it. Requests are latched as pending flags. The chosen vector is held until the CPU acknowledges it, and the acknowledge clears that source's flag.

Top module: `ic_vectored_irq`

## Requirements
- R1: A pending trap always wins over any maskable source. Among several pending traps, the lowest trap number wins. Trap t has vector index t (0..NUM_TRAP-1).
- R2: Maskable source s has vector index NUM_TRAP+s. When several qualifying sources are pending, the one with the highest user priority wins.
- R3: Among qualifying sources of equal user priority, the lower source number wins.
- R4: A maskable source is offered only when its enable bit is 1, its 3-bit priority field (bits 3s+2..3s of the priority bus) is nonzero, and that priority is strictly greater than the CPU priority. If no source qualifies, no request is raised.
- R5: The vector address is base + 2*index. The base is 0x000004 for the primary table and 0x000104 for the alternate table. The table is chosen by the select input at the cycle the winner is captured.
- R6: From idle with nothing pending, an input pulse sampled at one clock edge raises the request after the next clock edge. The request is not visible before then. This latency does not depend on how many sources are pending.
- R7: While the request is high and no acknowledge is given, the vector index and address stay unchanged, even if a higher-ranked source arrives.
- R8: An acknowledge sampled while the request is high clears the winner's pending flag and drops the request for at least one cycle. Arbitration then resumes among the remaining pending sources.
- R9: Pending flags are sticky: a one-cycle pulse stays pending until it is acknowledged. A new pulse on the same line in the same cycle as its acknowledge leaves the source pending.
- R10: After reset the request, vector index and vector address are all zero, and no source is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Maskable request lines, sampled into pending flags |
| trap_i | input | NUM_TRAP | Nonmaskable trap lines, sampled into pending flags |
| irq_en_i | input | NUM_SRC | Per-source enable |
| irq_prio_i | input | 3*NUM_SRC | Per-source user priority, 3 bits per source |
| cpu_prio_i | input | 3 | Current CPU priority |
| alt_sel_i | input | 1 | 1 selects the alternate vector table |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| req_o | output | 1 | Interrupt request to the CPU |
| vec_idx_o | output | 7 | Index of the winning vector entry |
| vec_addr_o | output | 24 | Program address of the winning vector entry |

## Verification
Two events can land in the same cycle. One is an acknowledge and a fresh pulse on the source being acknowledged. The other is a held request and the arrival of a higher-ranked trap. The bench provokes both on purpose. It pulses the trap while a maskable vector is held and confirms that the index does not move. It then acknowledges while re-pulsing the same source, and expects the trap to be served next, followed by the same source again. Randomized rounds with mixed priorities, enables and table selection are compared against a reference arbitration function computed in the bench.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int PRIO_W = 3;
  typedef enum logic {ST_IDLE, ST_HOLD} ic_state_e;
endpackage

// File: rtl/ic_pending.sv
module ic_pending #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_d;

  // a set in the same cycle as a clear wins, so nothing is lost
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_comb pend_d[g] = (pend_o[g] & ~clr_i[g]) | set_i[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= pend_d;
  end
endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter
  import ic_pkg::*;
#(
  parameter int NUM_TRAP = 8,
  parameter int NUM_SRC  = 32,
  parameter int IDX_W    = 7
) (
  input  logic [NUM_TRAP-1:0]       trap_pend_i,
  input  logic [NUM_SRC-1:0]        src_pend_i,
  input  logic [NUM_SRC-1:0]        src_en_i,
  input  logic [PRIO_W*NUM_SRC-1:0] src_prio_i,
  input  logic [PRIO_W-1:0]         cpu_prio_i,
  output logic                      win_valid_o,
  output logic [IDX_W-1:0]          win_idx_o
);
  logic [NUM_SRC-1:0] qual;
  logic [PRIO_W-1:0]  lvl [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
    assign lvl[g]  = src_prio_i[PRIO_W*g +: PRIO_W];
    assign qual[g] = src_pend_i[g] & src_en_i[g] & (lvl[g] > cpu_prio_i);
  end

  logic [PRIO_W-1:0] best_lvl;
  logic [IDX_W-1:0]  best_src;
  logic              trap_hit;
  logic [IDX_W-1:0]  trap_idx;

  always_comb begin
    best_lvl = '0;
    best_src = '0;
    // strict compare while scanning upward keeps the lower index on ties
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qual[i] && (lvl[i] > best_lvl)) begin
        best_lvl = lvl[i];
        best_src = IDX_W'(i);
      end
    end
    trap_hit = 1'b0;
    trap_idx = '0;
    for (int t = NUM_TRAP - 1; t >= 0; t--) begin
      if (trap_pend_i[t]) begin
        trap_hit = 1'b1;
        trap_idx = IDX_W'(t);
      end
    end
    win_valid_o = trap_hit | (best_lvl != '0);
    win_idx_o   = trap_hit ? trap_idx : (IDX_W'(NUM_TRAP) + best_src);
  end
endmodule

// File: rtl/ic_vector_gen.sv
module ic_vector_gen #(
  parameter int              IDX_W    = 7,
  parameter int              ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] PRI_BASE = 24'h000004,
  parameter logic [ADDR_W-1:0] ALT_BASE = 24'h000104
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              alt_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base;
  always_comb begin
    base   = alt_i ? ALT_BASE : PRI_BASE;
    addr_o = base + (ADDR_W'(idx_i) << 1);
  end
endmodule

// File: rtl/ic_vectored_irq.sv
module ic_vectored_irq
  import ic_pkg::*;
#(
  parameter int NUM_SRC       = 32,
  parameter int NUM_TRAP      = 8,
  parameter int TABLE_ENTRIES = 126,
  parameter int ADDR_W        = 24,
  parameter int PRI_BASE      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            irq_i,
  input  logic [NUM_TRAP-1:0]           trap_i,
  input  logic [NUM_SRC-1:0]            irq_en_i,
  input  logic [3*NUM_SRC-1:0]          irq_prio_i,
  input  logic [2:0]                    cpu_prio_i,
  input  logic                          alt_sel_i,
  input  logic                          ack_i,
  output logic                          req_o,
  output logic [$clog2(TABLE_ENTRIES)-1:0] vec_idx_o,
  output logic [ADDR_W-1:0]             vec_addr_o
);
  localparam int IDX_W     = $clog2(TABLE_ENTRIES);
  localparam int TBL_BYTES = TABLE_ENTRIES * 2;
  localparam int ALT_OFF   = ((TBL_BYTES + 255) / 256) * 256;
  localparam logic [ADDR_W-1:0] PRI_A = ADDR_W'(PRI_BASE);
  localparam logic [ADDR_W-1:0] ALT_A = ADDR_W'(PRI_BASE + ALT_OFF);

  logic [NUM_TRAP-1:0] trap_pend, trap_clr;
  logic [NUM_SRC-1:0]  src_pend, src_clr;
  logic                win_valid;
  logic [IDX_W-1:0]    win_idx;
  logic [ADDR_W-1:0]   win_addr;

  ic_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              load_en;
  logic              ack_hold;

  ic_pending #(.W(NUM_TRAP)) u_trap_pend (
    .clk(clk), .rst_n(rst_n), .set_i(trap_i), .clr_i(trap_clr), .pend_o(trap_pend)
  );

  ic_pending #(.W(NUM_SRC)) u_src_pend (
    .clk(clk), .rst_n(rst_n), .set_i(irq_i), .clr_i(src_clr), .pend_o(src_pend)
  );

  ic_arbiter #(.NUM_TRAP(NUM_TRAP), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .trap_pend_i(trap_pend),
    .src_pend_i (src_pend),
    .src_en_i   (irq_en_i),
    .src_prio_i (irq_prio_i),
    .cpu_prio_i (cpu_prio_i),
    .win_valid_o(win_valid),
    .win_idx_o  (win_idx)
  );

  ic_vector_gen #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .PRI_BASE(PRI_A), .ALT_BASE(ALT_A)) u_vgen (
    .idx_i (win_idx),
    .alt_i (alt_sel_i),
    .addr_o(win_addr)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    load_en  = 1'b0;
    ack_hold = 1'b0;
    unique case (state_q)
      ST_IDLE: if (win_valid) begin
        state_d = ST_HOLD;
        load_en = 1'b1;
      end
      ST_HOLD: if (ack_i) begin
        state_d  = ST_IDLE;
        ack_hold = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  for (genvar t = 0; t < NUM_TRAP; t++) begin : g_trap_clr
    assign trap_clr[t] = ack_hold && (idx_q == IDX_W'(t));
  end
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_clr
    assign src_clr[s] = ack_hold && (idx_q == IDX_W'(NUM_TRAP + s));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      addr_q <= '0;
    end else if (load_en) begin
      idx_q  <= win_idx;
      addr_q <= win_addr;
    end
  end

  assign req_o      = (state_q == ST_HOLD);
  assign vec_idx_o  = idx_q;
  assign vec_addr_o = addr_q;
endmodule

// File: rtl/ic_vectored_irq_chk.sv
module ic_vectored_irq_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_TRAP = 8,
  parameter int IDX_W    = 7,
  parameter int ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] PRI_A = 24'h4,
  parameter logic [ADDR_W-1:0] ALT_A = 24'h104
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_o,
  input logic                ack_i,
  input logic [IDX_W-1:0]    vec_idx_o,
  input logic [ADDR_W-1:0]   vec_addr_o,
  input logic [NUM_TRAP-1:0] trap_pend,
  input logic [NUM_SRC-1:0]  src_pend
);
  // R1: a pending trap wins the next capture
  assert_trap_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) && ($past(trap_pend) != '0) |-> (vec_idx_o < IDX_W'(NUM_TRAP)));

  // R4: no request is raised from an empty pending set
  assert_req_needs_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> ($past(trap_pend) != '0) || ($past(src_pend) != '0));

  // R5: address matches the index in one of the two tables
  assert_addr_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (vec_addr_o == PRI_A + (ADDR_W'(vec_idx_o) << 1)) ||
              (vec_addr_o == ALT_A + (ADDR_W'(vec_idx_o) << 1)));

  // R7: held vector does not move before acknowledge
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !ack_i |=> req_o && $stable(vec_idx_o) && $stable(vec_addr_o));

  // R8: acknowledge drops the request
  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && ack_i |=> !req_o);
endmodule

bind ic_vectored_irq ic_vectored_irq_chk #(
  .NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
  .PRI_A(PRI_A), .ALT_A(ALT_A)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_o(req_o), .ack_i(ack_i),
  .vec_idx_o(vec_idx_o), .vec_addr_o(vec_addr_o),
  .trap_pend(trap_pend), .src_pend(src_pend)
);

// File: tb/test_ic_vectored_irq.sv
`timescale 1ns/1ps
module test_ic_vectored_irq;
  localparam int NS = 32;
  localparam int NT = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NS-1:0]   irq_i;
  logic [NT-1:0]   trap_i;
  logic [NS-1:0]   irq_en_i;
  logic [3*NS-1:0] irq_prio_i;
  logic [2:0]      cpu_prio_i;
  logic            alt_sel_i;
  logic            ack_i;
  logic            req_o;
  logic [6:0]      vec_idx_o;
  logic [23:0]     vec_addr_o;

  int errors = 0;
  int checks = 0;
  bit m_src [NS];
  bit m_trap[NT];

  always #2 clk = ~clk;

  ic_vectored_irq i_ic_vectored_irq (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .trap_i(trap_i),
    .irq_en_i(irq_en_i), .irq_prio_i(irq_prio_i), .cpu_prio_i(cpu_prio_i),
    .alt_sel_i(alt_sel_i), .ack_i(ack_i), .req_o(req_o),
    .vec_idx_o(vec_idx_o), .vec_addr_o(vec_addr_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_win();
    for (int t = 0; t < NT; t++) if (m_trap[t]) return t;
    for (int l = 7; l >= 1; l--) begin
      if (l <= int'(cpu_prio_i)) break;
      for (int s = 0; s < NS; s++)
        if (m_src[s] && irq_en_i[s] && int'(irq_prio_i[3*s +: 3]) == l) return NT + s;
    end
    return -1;
  endfunction

  function automatic longint exp_addr(input int idx);
    return (alt_sel_i ? 64'h104 : 64'h4) + 2 * idx;
  endfunction

  task automatic set_prio(input int s, input int p);
    irq_prio_i[3*s +: 3] = 3'(p);
  endtask

  // called at a negedge; pulse held for one clock edge
  task automatic pulse(input logic [NS-1:0] sm, input logic [NT-1:0] tm);
    irq_i = sm; trap_i = tm;
    for (int s = 0; s < NS; s++) if (sm[s]) m_src[s] = 1;
    for (int t = 0; t < NT; t++) if (tm[t]) m_trap[t] = 1;
    @(negedge clk);
    irq_i = '0; trap_i = '0;
    chk(req_o == 1'b0, "R6 no early request", req_o, 0);
    @(negedge clk);
  endtask

  task automatic serve_all(input string tag);
    for (int n = 0; n < 200; n++) begin
      int w;
      w = exp_win();
      if (w < 0) begin
        chk(req_o == 1'b0, {tag, " idle when none qualifies"}, req_o, 0);
        break;
      end
      chk(req_o == 1'b1, {tag, " request"}, req_o, 1);
      chk(int'(vec_idx_o) == w, {tag, " winner index"}, vec_idx_o, w);
      chk(longint'(vec_addr_o) == exp_addr(w), "R5 vector address", vec_addr_o, exp_addr(w));
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      if (w < NT) m_trap[w] = 0; else m_src[w-NT] = 0;
      chk(req_o == 1'b0, "R8 request drops after ack", req_o, 0);
      @(negedge clk);
    end
  endtask

  task automatic cleanup();
    irq_en_i = '1; irq_prio_i = '1; cpu_prio_i = 3'd0;
    @(negedge clk);
    serve_all("R9 drain");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; irq_i = '0; trap_i = '0; irq_en_i = '0; irq_prio_i = '0;
    cpu_prio_i = '0; alt_sel_i = 1'b0; ack_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_o == 0, "R10 reset request", req_o, 0);
    chk(vec_idx_o == 0, "R10 reset index", vec_idx_o, 0);
    chk(vec_addr_o == 0, "R10 reset address", vec_addr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_o == 0, "R10 nothing pending after reset", req_o, 0);

    // R2 R3 R6: priority then index order
    irq_en_i = '1; irq_prio_i = '0; cpu_prio_i = 3'd2;
    set_prio(1, 5); set_prio(3, 5); set_prio(10, 6);
    pulse(NS'(32'h0000_040A), '0);
    serve_all("R2 R3 order");

    // R4: disabled, level zero, not above CPU
    irq_en_i = '1; irq_prio_i = '0; cpu_prio_i = 3'd2;
    set_prio(5, 2); set_prio(7, 7); irq_en_i[7] = 1'b0;
    pulse(NS'(32'h0000_00E0), '0);
    repeat (3) begin
      chk(req_o == 0, "R4 unqualified ignored", req_o, 0);
      @(negedge clk);
    end
    cleanup();

    // R1: traps first, lowest trap first
    irq_en_i = '1; irq_prio_i = '0; cpu_prio_i = 3'd0; set_prio(0, 7);
    pulse(NS'(1), NT'(8'h28));
    serve_all("R1 traps");

    // R7 and R9: hold while a trap arrives, ack with same-cycle re-pulse
    irq_en_i = '1; irq_prio_i = '0; set_prio(2, 3);
    pulse(NS'(4), '0);
    chk(req_o == 1 && vec_idx_o == 7'(NT + 2), "R7 initial hold", vec_idx_o, NT + 2);
    trap_i = NT'(1); m_trap[0] = 1;
    @(negedge clk);
    trap_i = '0;
    repeat (2) begin
      chk(req_o == 1 && vec_idx_o == 7'(NT + 2), "R7 vector held", vec_idx_o, NT + 2);
      @(negedge clk);
    end
    ack_i = 1'b1; irq_i = NS'(4);
    @(negedge clk);
    ack_i = 1'b0; irq_i = '0;
    chk(req_o == 0, "R8 drop after ack", req_o, 0);
    @(negedge clk);
    serve_all("R9 same-cycle re-pulse");

    // R5: alternate table
    alt_sel_i = 1'b1; irq_en_i = '1; irq_prio_i = '0; set_prio(4, 1);
    pulse(NS'(16), '0);
    serve_all("R5 alternate");
    alt_sel_i = 1'b0;

    // randomized rounds
    for (int r = 0; r < 40; r++) begin
      logic [NS-1:0] sm;
      logic [NT-1:0] tm;
      alt_sel_i  = 1'($urandom());
      irq_en_i   = NS'($urandom());
      irq_prio_i = {$urandom(), $urandom(), $urandom()};
      cpu_prio_i = 3'($urandom());
      sm = NS'($urandom());
      tm = (($urandom() % 4) == 0) ? NT'($urandom()) : '0;
      pulse(sm, tm);
      serve_all("R2 random");
      cleanup();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule